// File: doc/BRIEF.md
# Serial Interrupt Slave Frame Engine

This block is the peripheral side of a clock-counted serial interrupt wire. The wire is shared by several agents, open-drain and active low, with a weak pull-up, and it runs on the bus clock. The engine watches the sampled wire and recognises a start frame by its long low pulse. From the moment the wire returns high it counts clocks to know which interrupt frame is on the wire. Every frame lasts three clocks: a sample slot, a recovery slot and a turnaround slot. When the local request for a frame is pending at the start of its sample slot, the engine pulls the wire low. In the recovery slot that follows it drives the wire high, and in the turnaround slot it lets go.

The frames come in a fixed order after the start frame: sixteen interrupt frames numbered 0 to 15, then an I/O channel check frame, then the host's stop frame. The width of the stop frame sets the mode for the next cycle. In quiet mode the wire rests until some agent asks for a cycle, and an idle engine with a pending request asks by pulling the wire low for a single clock. All pins are plain level signals. Nothing flows through the block as a stream, so there is no handshake and no back-pressure. The two drive enables go to an open-drain pad that has a separate push-high enable.

Top module: `serirq_slave`

## Requirements
- R1: While reset is asserted, and after it is released, both drive enables are inactive. The engine starts idle in continuous mode and never requests a cycle by itself in that mode.
- R2: A start frame is recognised only when the wire is sampled low on at least START_MIN (4) consecutive rising edges and then sampled high. A shorter low pulse seen while idle starts nothing.
- R3: Call edge E the first rising edge that samples the wire high after the start frame. The sample slot of frame k (k = 0..16) is the clock period that begins at edge E+2+3k, its recovery slot begins at E+3+3k, and its turnaround slot begins at E+4+3k. Frames 0..15 belong to irq_req[0..15] and frame 16 belongs to chk_req. In turnaround slots, and in the start frame's own recovery and turnaround, neither enable is active.
- R4: drv_low is active for the whole sample slot of frame k exactly when the request for frame k is high at the edge that begins that slot.
- R5: drv_high is active in a recovery slot exactly when drv_low was active in the sample slot just before it.
- R6: drv_low and drv_high are never active together, and drv_high is never active unless drv_low was active in the clock before.
- R7: Requests are levels. A request dropped before the edge that begins its sample slot is not sent, and a request that stays high is sent again in every cycle.
- R8: After the turnaround of frame 16, the low width of the stop frame sets the mode for later cycles: QUIET_LEN (2) clocks selects quiet mode, and CONT_LEN (3) or more clocks selects continuous mode.
- R9: In quiet mode, when the engine is idle, the wire is sampled high, any request is high and no request pulse has been issued since the last recognised start frame, drv_low is active for exactly one clock. It does not pulse again until a start frame has been recognised.
- R10: In continuous mode the engine never drives the wire outside the frames.
- R11: Asserting reset in the middle of a cycle clears both enables at once and returns the engine to idle in continuous mode, so that later frames on the wire are not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Wire level as seen by the pad, 1 = high |
| irq_req | input | NUM_IRQ (16) | Level interrupt requests, bit k goes in frame k |
| chk_req | input | 1 | I/O channel check request, sent in frame 16 |
| drv_low | output | 1 | Enable to pull the wire low |
| drv_high | output | 1 | Enable to push the wire high |

## Verification
The assertions assume that line_in is synchronous to clk and that the host produces well-formed cycles. That means a start frame only while the engine is idle, and a stop frame only after the turnaround of frame 16. They also assume that no other agent drives the wire in the slots this engine owns. The bench models the wire as the AND of the engine's pull-down and a host pull-down on a pull-up. It changes the host drive and the requests only on falling clock edges. Every cycle it generates has exactly the R3 frame count, with a start pulse of four clocks and a stop pulse of two or three clocks. The only ill-formed input it applies is a three-clock low pulse while idle, which the design must ignore.

// File: rtl/serirq_pkg.sv
`timescale 1ns/1ps
package serirq_pkg;

  // Which slot of a frame the current clock period is.
  typedef enum logic [1:0] {
    SLOT_SAMPLE  = 2'd0,
    SLOT_RECOVER = 2'd1,
    SLOT_TURN    = 2'd2
  } slot_e;

  // Engine phase across a whole serial cycle.
  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_FRAMES = 2'd1,
    ENG_STOP   = 2'd2
  } eng_e;

  // Mode chosen by the previous stop frame.
  typedef enum logic {
    MODE_CONT  = 1'b0,
    MODE_QUIET = 1'b1
  } mode_e;

endpackage

// File: rtl/serirq_low_meter.sv
`timescale 1ns/1ps
// Measures runs of low samples on the wire and reports each run's length
// on the edge that first samples the wire high again.
module serirq_low_meter #(
  parameter int MAX_RUN = 15,
  parameter int RW      = $clog2(MAX_RUN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_in,
  output logic          run_done,
  output logic [RW-1:0] run_len
);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!line_in) begin
      if (cnt_q != RW'(MAX_RUN)) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign run_done = line_in && (cnt_q != '0);
  assign run_len  = cnt_q;

endmodule

// File: rtl/serirq_slot_seq.sv
`timescale 1ns/1ps
// Tracks the cycle phase, the frame index and the slot inside each frame,
// and keeps the mode chosen by the last stop frame.
module serirq_slot_seq
  import serirq_pkg::*;
#(
  parameter int NUM_IRQ   = 16,
  parameter int START_MIN = 4,
  parameter int QUIET_LEN = 2,
  parameter int CONT_LEN  = 3,
  parameter int RW        = 4,
  parameter int FW        = $clog2(NUM_IRQ + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_done,
  input  logic [RW-1:0] run_len,
  output eng_e          state_q,
  output eng_e          state_d,
  output slot_e         slot_d,
  output logic [FW-1:0] frame_d,
  output mode_e         mode_q,
  output logic          start_hit
);

  localparam logic [FW-1:0] CHK_ID   = FW'(NUM_IRQ);
  localparam logic [FW-1:0] START_ID = FW'(NUM_IRQ + 1);

  slot_e         slot_q;
  logic [FW-1:0] frame_q;
  logic          stop_hit;

  assign start_hit = (state_q == ENG_IDLE) && run_done && (run_len >= RW'(START_MIN));
  assign stop_hit  = (state_q == ENG_STOP) && run_done;

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    frame_d = frame_q;
    case (state_q)
      ENG_IDLE: begin
        if (start_hit) begin
          state_d = ENG_FRAMES;
          slot_d  = SLOT_RECOVER;
          frame_d = START_ID;
        end
      end
      ENG_FRAMES: begin
        case (slot_q)
          SLOT_RECOVER: slot_d = SLOT_TURN;
          SLOT_TURN: begin
            if (frame_q == CHK_ID) begin
              state_d = ENG_STOP;
            end else begin
              slot_d  = SLOT_SAMPLE;
              frame_d = (frame_q == START_ID) ? FW'(0) : frame_q + 1'b1;
            end
          end
          default: slot_d = SLOT_RECOVER;
        endcase
      end
      default: begin
        if (stop_hit) state_d = ENG_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      slot_q  <= SLOT_TURN;
      frame_q <= START_ID;
      mode_q  <= MODE_CONT;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      frame_q <= frame_d;
      if (stop_hit) begin
        if (run_len == RW'(QUIET_LEN))      mode_q <= MODE_QUIET;
        else if (run_len >= RW'(CONT_LEN))  mode_q <= MODE_CONT;
      end
    end
  end

endmodule

// File: rtl/serirq_drive.sv
`timescale 1ns/1ps
// Registers the two pad enables from the next slot. It also issues the
// one-clock cycle request in quiet mode.
module serirq_drive
  import serirq_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int FW      = $clog2(NUM_IRQ + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_in,
  input  eng_e               state_q,
  input  eng_e               state_d,
  input  slot_e              slot_d,
  input  logic [FW-1:0]      frame_d,
  input  mode_e              mode_q,
  input  logic               start_hit,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               chk_req,
  output logic               drv_low,
  output logic               drv_high
);

  localparam int PADW = 1 << FW;

  logic [PADW-1:0] req_pad;
  logic            any_req;
  logic            in_frames_d;
  logic            kick_sent_q;
  logic            kick;

  assign req_pad     = PADW'({chk_req, irq_req});
  assign any_req     = |{chk_req, irq_req};
  assign in_frames_d = (state_d == ENG_FRAMES);
  assign kick        = (state_q == ENG_IDLE) && (state_d == ENG_IDLE) &&
                       (mode_q == MODE_QUIET) && line_in && any_req && !kick_sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_low     <= 1'b0;
      drv_high    <= 1'b0;
      kick_sent_q <= 1'b0;
    end else begin
      drv_low  <= 1'b0;
      drv_high <= 1'b0;
      if (start_hit)  kick_sent_q <= 1'b0;
      else if (kick)  kick_sent_q <= 1'b1;
      if (in_frames_d && (slot_d == SLOT_SAMPLE)) begin
        drv_low <= req_pad[frame_d];
      end else if (in_frames_d && (slot_d == SLOT_RECOVER)) begin
        drv_high <= drv_low;
      end else if (kick) begin
        drv_low <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/serirq_slave.sv
`timescale 1ns/1ps
module serirq_slave
  import serirq_pkg::*;
#(
  parameter int NUM_IRQ   = 16,
  parameter int START_MIN = 4,
  parameter int QUIET_LEN = 2,
  parameter int CONT_LEN  = 3,
  parameter int MAX_RUN   = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_in,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               chk_req,
  output logic               drv_low,
  output logic               drv_high
);

  localparam int RW = $clog2(MAX_RUN + 1);
  localparam int FW = $clog2(NUM_IRQ + 2);

  logic          run_done;
  logic [RW-1:0] run_len;
  eng_e          state_q;
  eng_e          state_d;
  slot_e         slot_d;
  logic [FW-1:0] frame_d;
  mode_e         mode_q;
  logic          start_hit;
  logic          in_frames;
  logic          quiet_mode;

  assign in_frames  = (state_q == ENG_FRAMES);
  assign quiet_mode = (mode_q == MODE_QUIET);

  serirq_low_meter #(.MAX_RUN(MAX_RUN), .RW(RW)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (line_in),
    .run_done (run_done),
    .run_len  (run_len)
  );

  serirq_slot_seq #(
    .NUM_IRQ   (NUM_IRQ),
    .START_MIN (START_MIN),
    .QUIET_LEN (QUIET_LEN),
    .CONT_LEN  (CONT_LEN),
    .RW        (RW),
    .FW        (FW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_done  (run_done),
    .run_len   (run_len),
    .state_q   (state_q),
    .state_d   (state_d),
    .slot_d    (slot_d),
    .frame_d   (frame_d),
    .mode_q    (mode_q),
    .start_hit (start_hit)
  );

  serirq_drive #(.NUM_IRQ(NUM_IRQ), .FW(FW)) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .state_q   (state_q),
    .state_d   (state_d),
    .slot_d    (slot_d),
    .frame_d   (frame_d),
    .mode_q    (mode_q),
    .start_hit (start_hit),
    .irq_req   (irq_req),
    .chk_req   (chk_req),
    .drv_low   (drv_low),
    .drv_high  (drv_high)
  );

endmodule

// File: rtl/serirq_slave_chk.sv
`timescale 1ns/1ps
module serirq_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic line_in,
  input logic drv_low,
  input logic drv_high,
  input logic in_frames,
  input logic quiet_mode
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (!drv_low && !drv_high);
    end
  end

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_low && drv_high));

  assert_high_needs_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_high |-> $past(drv_low));

  assert_recover_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_low && in_frames) |=> drv_high);

  assert_kick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_low && !in_frames) |=> !drv_low);

  assert_kick_line_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_low && !in_frames) |-> $past(line_in));

  assert_kick_quiet_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_low && !in_frames) |-> quiet_mode);

endmodule

bind serirq_slave serirq_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_in    (line_in),
  .drv_low    (drv_low),
  .drv_high   (drv_high),
  .in_frames  (in_frames),
  .quiet_mode (quiet_mode)
);

// File: tb/serirq_slave_bench.sv
`timescale 1ns/1ps
module serirq_slave_bench;

  localparam int NIRQ = 16;
  // entry = {irq[15:0], chk, stop_len[1:0]}
  localparam logic [18:0] VEC [6] = '{
    {16'h0000, 1'b0, 2'd3},
    {16'h0001, 1'b0, 2'd3},
    {16'h8000, 1'b1, 2'd3},
    {16'hA5A5, 1'b0, 2'd3},
    {16'hFFFF, 1'b1, 2'd3},
    {16'h0000, 1'b0, 2'd2}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            host_low = 1'b0;
  logic            chk_req = 1'b0;
  logic [NIRQ-1:0] irq_req = '0;
  logic            drv_low;
  logic            drv_high;
  logic            line_in;
  int              checks = 0;
  int              errors = 0;
  bit              finished = 1'b0;

  always #10 clk = ~clk;

  assign line_in = ~(drv_low | host_low);

  serirq_slave u_serirq_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (line_in),
    .irq_req  (irq_req),
    .chk_req  (chk_req),
    .drv_low  (drv_low),
    .drv_high (drv_high)
  );

  task automatic check(input string what, input logic [1:0] exp);
    checks++;
    if ({drv_low, drv_high} !== exp) begin
      errors++;
      $display("FAIL %s actual={low,high}=%b expected=%b at %0t", what, {drv_low, drv_high}, exp, $time);
    end
  endtask

  task automatic idle_check(input int n, input string what, input logic [1:0] exp);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(what, exp);
    end
  endtask

  // One full serial cycle driven by the host; called and returns at a negedge.
  task automatic run_cycle(input logic [15:0] req, input logic chk, input int stop_len,
                           input logic [16:0] drop_mask, input int drop_at);
    logic [16:0] cur;
    logic [16:0] expv;
    cur     = {chk, req};
    expv    = '0;
    irq_req = req;
    chk_req = chk;
    host_low = 1'b1;
    repeat (4) @(negedge clk);
    host_low = 1'b0;
    for (int n = 1; n <= 53; n++) begin
      @(negedge clk);
      if (n < 3) begin
        check("R3 start frame recovery/turnaround", 2'b00);
      end else begin
        int k;
        int ph;
        k  = (n - 3) / 3;
        ph = (n - 3) % 3;
        if (ph == 0)      check($sformatf("R4 R7 sample slot frame %0d", k), {expv[k], 1'b0});
        else if (ph == 1) check($sformatf("R5 recovery slot frame %0d", k), {1'b0, expv[k]});
        else              check($sformatf("R3 turnaround frame %0d", k), 2'b00);
      end
      if (n == drop_at) begin
        cur     = cur & ~drop_mask;
        irq_req = cur[15:0];
        chk_req = cur[16];
      end
      if ((n >= 2) && ((n - 2) % 3 == 0) && ((n - 2) / 3 <= 16)) expv[(n - 2) / 3] = cur[(n - 2) / 3];
    end
    @(negedge clk);
    check("R3 stop frame not driven", 2'b00);
    host_low = 1'b1;
    repeat (stop_len) @(negedge clk);
    host_low = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R3 watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset state, with requests present during reset
    irq_req = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R1 outputs idle in reset", 2'b00);
    rst_n = 1'b1;
    idle_check(4, "R1 R10 idle after reset, continuous", 2'b00);
    irq_req = '0;

    // Short low pulse must not start a cycle
    irq_req = 16'h0001;
    host_low = 1'b1;
    repeat (3) @(negedge clk);
    host_low = 1'b0;
    idle_check(8, "R2 three-clock pulse ignored", 2'b00);

    // Vector walk
    for (int i = 0; i < 6; i++) begin
      run_cycle(VEC[i][18:3], VEC[i][2], int'(VEC[i][1:0]), '0, 0);
      idle_check(2, "R10 R8 idle between cycles", 2'b00);
    end

    // Now quiet: a new request produces a one-clock pulse
    irq_req = 16'h0008;
    @(negedge clk);
    check("R9 R8 quiet-mode request pulse", 2'b10);
    idle_check(4, "R9 pulse not repeated", 2'b00);

    // Host answers; level request sent, then pulse again after quiet stop
    run_cycle(16'h0008, 1'b0, 2, '0, 0);
    @(negedge clk);
    check("R9 no pulse on stop edge", 2'b00);
    @(negedge clk);
    check("R7 R9 level request pulses again", 2'b10);
    idle_check(2, "R9 single pulse", 2'b00);

    // Drop two requests mid-cycle; switch back to continuous
    run_cycle(16'hFFFF, 1'b1, 3, 17'h10400, 20);
    idle_check(6, "R10 R8 continuous: no pulse with requests", 2'b00);

    // Reset in the middle of a cycle
    irq_req = 16'hFFFF;
    host_low = 1'b1;
    repeat (4) @(negedge clk);
    host_low = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 frame 0 driven before reset", 2'b10);
    rst_n = 1'b0;
    #1;
    check("R11 async reset clears enables", 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    idle_check(12, "R11 engine idle after mid-cycle reset", 2'b00);

    run_cycle(16'h1234, 1'b0, 3, '0, 0);
    idle_check(3, "R10 idle after final cycle", 2'b00);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule